// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation converter. Software starts a conversion by writing 1 to a start/busy bit. The sequencer derives a conversion clock period (TAD) from the system clock, or from an external slow enable. It then runs a fixed twelve-TAD frame. In the first TAD it isolates the hold capacitor. In the next ten TADs it resolves one result bit each, most significant bit first. In the last TAD it reconnects the capacitor and latches the code. The frame never ends early.

The DAC, comparator and capacitor are outside the block. Each trial code goes out on `trial_code`, and a single comparator decision comes back on `cmp_in`. On completion the block clears the start/busy bit and raises a one-clock completion pulse, so software can either poll or take an interrupt. A recovery gap of two TADs then follows. A start written inside that gap is held and begins as soon as the gap ends.

States:
- `S_IDLE`: waiting for a start.
- `S_DISC`: capacitor isolated.
- `S_TRIAL`: ten bit trials.
- `S_LATCH`: reconnect and latch.
- `S_GAP`: recovery.

Transitions:
- start: `S_IDLE` to `S_DISC`, on a write of 1.
- isolate-done: `S_DISC` to `S_TRIAL`, on a TAD tick.
- last-trial: `S_TRIAL` to `S_LATCH`, on the tick of bit 0.
- latch: `S_LATCH` to `S_GAP`, on a tick.
- gap-restart: `S_GAP` to `S_DISC`, when the gap ends with a start pending.
- gap-idle: `S_GAP` to `S_IDLE`, when the gap ends with no start pending.
- abort: any of `S_DISC`, `S_TRIAL` or `S_LATCH` to `S_IDLE`, on a write of 0.

Top module: `sar_seq`

## Requirements
- R1: After reset `go_bit`, `sample_open` and `done_irq` are 0, and the result reads 0.
- R2: Once started, the frame lasts exactly 12 TAD. `sample_open` is 1 from the clock after the start through the ten trial TADs, and 0 during the final latch TAD. The held input therefore ignores input changes after the start.
- R3: Bits are tried MSB first. A trial drives the kept bits with the tried bit set to 1. `cmp_in`=1 (held input >= trial code) keeps the bit and `cmp_in`=0 clears it. The first trial code is 0x200, and an ideal comparator yields the held input exactly.
- R4: Frame length does not depend on the input value. All ten trials always run.
- R5: `div_sel` picks the TAD length in system clocks: 000=2, 100=4, 001=8, 101=16, 010=32, 110=64.
- R6: At the latch edge `go_bit` goes to 0 and `done_irq` is 1 for exactly one clock.
- R7: The result is right-justified. `res_hi[1:0]` holds bits 9:8, `res_hi[7:2]` is 0, and `res_lo` holds bits 7:0. The result holds its value until the next latch.
- R8: After a latch, 2 TAD pass before the next frame. A start written in that window reads back as `go_bit`=1 and begins a frame exactly when the window ends.
- R9: Writing 1 while a frame is running has no effect on its length or its result.
- R10: Writing 0 during a frame aborts it. On the next clock `go_bit` and `sample_open` are 0, no `done_irq` follows, and the previous result is kept.
- R11: `div_sel` codes 011 and 111 make each clock with `ext_tad_en`=1 one TAD. The divider is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_wr | input | 1 | Write strobe for the start/busy bit |
| go_wdata | input | 1 | Value written to the start/busy bit |
| div_sel | input | 3 | TAD source and divider select |
| ext_tad_en | input | 1 | External slow TAD enable |
| cmp_in | input | 1 | Comparator decision, 1 = held input >= trial code |
| go_bit | output | 1 | Start/busy bit read-back |
| sample_open | output | 1 | 1 = hold capacitor isolated from the input |
| trial_code | output | 10 | Code driven to the DAC |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| done_irq | output | 1 | One-clock completion pulse |

## Verification
With N system clocks per TAD and a start write captured at edge E0:
- `sample_open` rises right after E0.
- The first trial code 0x200 appears after edge E(N).
- Reconnect is visible after E(11N).
- The result, the cleared `go_bit` and `done_irq` are all visible after E(12N).
- A frame held off by the gap opens the capacitor after E(14N).

The bench samples on falling edges and counts those edges from the start write. Each check fires at exactly the count derived from these edges, and total frame length is checked as 12N+1 falling edges up to the one where `go_bit` reads 0. An abort is checked on the falling edge right after the write. In external-enable mode every enabled clock is one TAD, so completion is due 12 edges after the enable is raised.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DISC  = 3'd1,
        S_TRIAL = 3'd2,
        S_LATCH = 3'd3,
        S_GAP   = 3'd4
    } seq_state_t;

    localparam int SEL_W = 3;

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
    import sar_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             ext_tad_en,
    output logic             tad_tick
);

    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] div_len;
    logic [2:0]       shamt;
    logic             ext_mode;
    logic             end_cnt;

    // shift = 2*sel[1:0] + sel[2] + 1 gives 2,4,8,16,32,64
    always_comb begin
        ext_mode = (div_sel[1:0] == 2'b11);
        shamt    = {div_sel[1:0], 1'b0} + {2'b00, div_sel[2]} + 3'd1;
        div_len  = LEN_W'(1) << shamt;
        end_cnt  = ({1'b0, cnt_q} == (div_len - LEN_W'(1)));
        tad_tick = run && (ext_mode ? ext_tad_en : end_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || ext_mode || end_cnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R5: divider counter stays below the selected TAD length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ext_mode) |-> ({1'b0, cnt_q} < div_len));

    // R11: external mode never lets the divider count
    p_ext_no_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> (cnt_q == '0));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    input  logic             trial_on,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_code,
    output logic [RES_W-1:0] sar_val,
    output logic             last_bit
);

    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q  <= '0;
            step_q <= '0;
        end else if (load) begin
            sar_q  <= '0;
            step_q <= MSB_ONLY;
        end else if (step_en) begin
            if (cmp_in) begin
                sar_q <= sar_q | step_q;
            end
            step_q <= step_q >> 1;
        end
    end

    always_comb begin
        trial_code = trial_on ? (sar_q | step_q) : sar_q;
        sar_val    = sar_q;
        last_bit   = step_q[0];
    end

    // R3: a single trial bit at a time
    p_step_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_q));

    // R3: bits at and below the trial position are still unresolved (zero)
    p_lower_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_on && step_q != '0) |-> ((sar_q & (step_q | (step_q - RES_W'(1)))) == '0));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int CNT_W    = 6,
    parameter int GAP_TADS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_wr,
    input  logic             go_wdata,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             ext_tad_en,
    input  logic             cmp_in,
    output logic             go_bit,
    output logic             sample_open,
    output logic [RES_W-1:0] trial_code,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo,
    output logic             done_irq
);

    localparam int GAP_W = $clog2(GAP_TADS + 1);

    seq_state_t       state_q, state_nx;
    logic             go_q, go_nx;
    logic [RES_W-1:0] res_q;
    logic             irq_q;
    logic [GAP_W-1:0] gap_cnt_q;

    logic             tad_tick;
    logic             run;
    logic             busy;
    logic             go_set, go_clr, abort;
    logic             latch_now, gap_end;
    logic             load, step_en, trial_on;
    logic             last_bit;
    logic [RES_W-1:0] sar_val;
    logic [15:0]      res_wide;

    sar_tad_gen #(.CNT_W(CNT_W)) u_tad (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .div_sel    (div_sel),
        .ext_tad_en (ext_tad_en),
        .tad_tick   (tad_tick)
    );

    sar_bit_engine #(.RES_W(RES_W)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step_en    (step_en),
        .trial_on   (trial_on),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .sar_val    (sar_val),
        .last_bit   (last_bit)
    );

    // decode of writes and frame events
    always_comb begin
        go_set    = go_wr && go_wdata;
        go_clr    = go_wr && !go_wdata;
        busy      = (state_q == S_DISC) || (state_q == S_TRIAL) || (state_q == S_LATCH);
        abort     = busy && go_clr;
        latch_now = (state_q == S_LATCH) && tad_tick && !abort;
        gap_end   = (state_q == S_GAP) && tad_tick
                    && (gap_cnt_q == GAP_W'(GAP_TADS - 1));
    end

    // next state and start/busy bit
    always_comb begin
        state_nx = state_q;
        go_nx    = go_q;
        unique case (state_q)
            S_IDLE: begin
                if (go_set) begin
                    go_nx    = 1'b1;
                    state_nx = S_DISC;
                end
            end
            S_DISC: begin
                if (abort) begin
                    go_nx    = 1'b0;
                    state_nx = S_IDLE;
                end else if (tad_tick) begin
                    state_nx = S_TRIAL;
                end
            end
            S_TRIAL: begin
                if (abort) begin
                    go_nx    = 1'b0;
                    state_nx = S_IDLE;
                end else if (tad_tick && last_bit) begin
                    state_nx = S_LATCH;
                end
            end
            S_LATCH: begin
                if (abort) begin
                    go_nx    = 1'b0;
                    state_nx = S_IDLE;
                end else if (latch_now) begin
                    go_nx    = 1'b0;
                    state_nx = S_GAP;
                end
            end
            S_GAP: begin
                if (go_set) begin
                    go_nx = 1'b1;
                end else if (go_clr) begin
                    go_nx = 1'b0;
                end
                if (gap_end) begin
                    state_nx = go_nx ? S_DISC : S_IDLE;
                end
            end
            default: begin
                go_nx    = 1'b0;
                state_nx = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            go_q      <= 1'b0;
            res_q     <= '0;
            irq_q     <= 1'b0;
            gap_cnt_q <= '0;
        end else begin
            state_q <= state_nx;
            go_q    <= go_nx;
            irq_q   <= latch_now;
            if (latch_now) begin
                res_q <= sar_val;
            end
            if (state_q != S_GAP) begin
                gap_cnt_q <= '0;
            end else if (tad_tick) begin
                gap_cnt_q <= gap_cnt_q + GAP_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        run         = (state_q != S_IDLE);
        trial_on    = (state_q == S_TRIAL);
        sample_open = (state_q == S_DISC) || (state_q == S_TRIAL);
        load        = (state_nx == S_DISC) && (state_q != S_DISC);
        step_en     = trial_on && tad_tick && !abort;
        go_bit      = go_q;
        done_irq    = irq_q;
        res_wide    = 16'(res_q);
        res_hi      = res_wide[15:8];
        res_lo      = res_wide[7:0];
    end

    // R6: completion pulse lasts one clock
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R6: completion pulse coincides with a cleared start bit
    p_irq_go_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !go_bit);

    // R7: the result moves only together with a completion
    p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_hi, res_lo}) |-> done_irq);

    // R2: a start from idle isolates the capacitor on the next clock
    p_open_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && go_wr && go_wdata) |=> sample_open);

    // R10: a zero write during a frame returns to idle
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_wr && !go_wdata) |=> (!go_bit && !sample_open && !done_irq));

    // R9: a one write while busy keeps the frame running
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRIAL && go_wr && go_wdata) |=> go_bit);

endmodule

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_wr = 1'b0;
    logic       go_wdata = 1'b0;
    logic [2:0] div_sel = 3'b000;
    logic       ext_tad_en = 1'b0;
    logic       cmp_in;
    logic       go_bit;
    logic       sample_open;
    logic [9:0] trial_code;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       done_irq;

    logic [9:0] vin = 10'd0;
    logic [9:0] held = 10'd0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // {div_sel, input at start, input after start}
    localparam logic [22:0] VEC [6] = '{
        {3'b000, 10'h3FF, 10'h000},
        {3'b100, 10'h000, 10'h3FF},
        {3'b001, 10'h155, 10'h2AA},
        {3'b101, 10'h2AA, 10'h000},
        {3'b010, 10'h201, 10'h005},
        {3'b110, 10'h1FF, 10'h3FF}
    };

    always #10 clk = ~clk;

    // analog model: tracking capacitor and ideal comparator
    always @(posedge clk) begin
        if (!sample_open) held <= vin;
    end
    assign cmp_in = (held >= trial_code);

    sar_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_wr      (go_wr),
        .go_wdata   (go_wdata),
        .div_sel    (div_sel),
        .ext_tad_en (ext_tad_en),
        .cmp_in     (cmp_in),
        .go_bit     (go_bit),
        .sample_open(sample_open),
        .trial_code (trial_code),
        .res_hi     (res_hi),
        .res_lo     (res_lo),
        .done_irq   (done_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    function automatic int tad_len(input logic [2:0] s);
        case (s)
            3'b000:  return 2;
            3'b100:  return 4;
            3'b001:  return 8;
            3'b101:  return 16;
            3'b010:  return 32;
            3'b110:  return 64;
            default: return 0;
        endcase
    endfunction

    function automatic int result_now();
        return {res_hi[1:0], res_lo};
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_go(input logic v);
        @(negedge clk);
        go_wr    = 1'b1;
        go_wdata = v;
        @(negedge clk);
        go_wr    = 1'b0;
    endtask

    // full frame with divider; poke > 0 writes 1 at that falling edge
    task automatic run_conv(input logic [2:0] sel, input logic [9:0] v1,
                            input logic [9:0] v2, input int poke, input string dur_req);
        int n;
        int irqs;
        int tl;
        tl      = tad_len(sel);
        div_sel = sel;
        vin     = v1;
        write_go(1'b1);
        n    = 1;
        irqs = 0;
        check_eq("R2 open after start", sample_open, 1);
        while (go_bit && n < 2000) begin
            @(negedge clk);
            n++;
            go_wr    = (n == poke);
            go_wdata = 1'b1;
            if (n == 2) vin = v2;
            if (done_irq) irqs++;
            if (n == tl + 1)      check_eq("R3 first trial code", trial_code, 10'h200);
            if (n == 11 * tl + 1) check_eq("R2 reconnect in last TAD", sample_open, 0);
        end
        go_wr = 1'b0;
        check_eq(dur_req, n, 12 * tl + 1);
        check_eq("R6 irq at latch", done_irq, 1);
        check_eq("R6 single irq", irqs, 1);
        check_eq("R3 result value", result_now(), v1);
        check_eq("R7 high byte upper bits", res_hi[7:2], 0);
        repeat (140) @(negedge clk);
        check_eq("R7 result held", result_now(), v1);
        check_eq("R6 irq cleared", done_irq, 0);
    endtask

    initial begin
        int n;
        int irqs;
        int tl;
        repeat (5) @(negedge clk);
        check_eq("R1 go_bit", go_bit, 0);
        check_eq("R1 sample_open", sample_open, 0);
        check_eq("R1 done_irq", done_irq, 0);
        check_eq("R1 result", result_now(), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // vector walk: R4 (value independence) and R5 (divider codes)
        for (int i = 0; i < 6; i++) begin
            run_conv(VEC[i][22:20], VEC[i][19:10], VEC[i][9:0], 0,
                     (i % 2 == 0) ? "R4 frame length" : "R5 TAD length");
        end

        // R9: a one write mid-frame changes nothing
        run_conv(3'b001, 10'h0F0, 10'h0F0, 20, "R9 frame length with extra write");

        // R10: abort keeps previous result (0x0F0)
        div_sel = 3'b000;
        vin     = 10'h123;
        write_go(1'b1);
        repeat (5) @(negedge clk);
        go_wr    = 1'b1;
        go_wdata = 1'b0;
        @(negedge clk);
        go_wr = 1'b0;
        check_eq("R10 go_bit cleared", go_bit, 0);
        check_eq("R10 capacitor reconnected", sample_open, 0);
        irqs = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done_irq) irqs++;
        end
        check_eq("R10 no irq", irqs, 0);
        check_eq("R10 result kept", result_now(), 10'h0F0);
        run_conv(3'b000, 10'h123, 10'h321, 0, "R10 frame after abort");

        // R8: start written during the gap
        tl      = tad_len(3'b100);
        div_sel = 3'b100;
        vin     = 10'h0AB;
        write_go(1'b1);
        n = 1;
        while (go_bit && n < 2000) begin
            @(negedge clk);
            n++;
        end
        go_wr    = 1'b1;
        go_wdata = 1'b1;
        vin      = 10'h36C;
        @(negedge clk);
        go_wr = 1'b0;
        n     = 1;
        check_eq("R8 held start reads back", go_bit, 1);
        check_eq("R8 closed during gap", sample_open, 0);
        while (!sample_open && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check_eq("R8 gap length", n, 2 * tl);
        while (go_bit && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check_eq("R8 held frame length", n, 14 * tl);
        check_eq("R8 held frame result", result_now(), 10'h36C);
        repeat (40) @(negedge clk);

        // R11: external enable as TAD for both codes
        for (int j = 0; j < 2; j++) begin
            div_sel    = (j == 0) ? 3'b111 : 3'b011;
            ext_tad_en = 1'b0;
            vin        = (j == 0) ? 10'h2C7 : 10'h018;
            write_go(1'b1);
            repeat (40) @(negedge clk);
            check_eq("R11 stalled without enable", go_bit, 1);
            check_eq("R11 still isolated", sample_open, 1);
            ext_tad_en = 1'b1;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (go_bit && n < 100);
            check_eq("R11 frame in enabled clocks", n, 12);
            check_eq("R11 result", result_now(), (j == 0) ? 10'h2C7 : 10'h018);
            repeat (4) @(negedge clk);
            ext_tad_en = 1'b0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule